// File: doc/BRIEF.md
# Embedded Panel Power Sequencer

This block steps an embedded display panel through its power-up and power-down phases under the control of a 32-bit control register. Software sets or clears a power-target bit. The sequencer then raises the panel supply, waits a programmable delay, and reports the powered-on steady state. Only then does it let the backlight come on. On the way down it first drops the backlight, then the supply, then holds a cycle delay before it accepts a new power-up. All delays count ticks of a fixed prescaler.

A supply-override bit keeps the panel supply up outside the sequence, so that a side channel can talk to the panel while it is off. The sequencer clears this override itself once the panel is on and sets it again once power-down has finished. The target, reset and override bits are guarded by a 16-bit key that must come with the same write. A sticky timeout flag marks any transition that runs longer than a programmable number of ticks.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset the control readback, the status word, `panel_vdd` and `backlight_en` are all zero.
- R2: Control bit 0 (power target), bit 1 (power reset) and bit 3 (supply override) change only on a control write that carries 0xABCD in bits 31:16. A write without the key leaves them unchanged. Bit 2 (backlight enable) takes the written value with or without the key. Readback bits 31:4 are zero.
- R3: After a write that sets the target from the off state, the supply rises one cycle later. Status bit 0 (on) and status field [6:4] = 2 (on state) follow between UP×DIV+2 and (UP+1)×DIV+1 cycles after the write edge, where UP is the power-up delay in ticks and DIV is the tick period in cycles.
- R4: The sequencer clears the supply override in the cycle the on state is reached, and sets it in the cycle the off state (code 0) is re-entered after a power-down.
- R5: `backlight_en` is high only in the on state with control bit 2 set. It stays low throughout power-up.
- R6: Clearing the target from the on state gives this order: the backlight drops (state 3), then after the backlight delay the sequenced supply drops (state 4), then after the down delay status bit 0 clears (state 5), then after the cycle delay the state returns to 0.
- R7: Clearing the target during power-up does not drop the supply. The power-up phase completes, the on state is reported, and then a full power-down follows.
- R8: Setting control bit 1 in the on state runs a full power-down and cycle delay, then powers up again while the target stays set. Bit 1 clears itself when the power-down starts.
- R9: Status bit 2 is set when a transition (states 1, 3, 4, 5) lasts more than the maximum tick count. It stays set until a status write with bit 2 at one, and a transition within the limit leaves it clear.
- R10: When a software write to the override bit falls in the same cycle as the sequencer's own update of that bit, the sequencer's value wins.
- R11: In the off state, a set override bit drives `panel_vdd` high while status bit 0 stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = status register (clear timeout) |
| wr_data | input | 32 | Write data, key in bits 31:16 |
| dly_up | input | DLY_W | Power-up delay in ticks |
| dly_bl_off | input | DLY_W | Backlight-off to supply-off delay in ticks |
| dly_down | input | DLY_W | Supply-off settle delay in ticks |
| dly_cycle | input | DLY_W | Minimum off time before a new power-up, in ticks |
| max_ticks | input | TO_W | Timeout limit for one transition, in ticks |
| ctrl_rd | output | 32 | Control register readback |
| status | output | 32 | [0] on, [1] in transition, [2] timeout, [6:4] state code |
| panel_vdd | output | 1 | Panel supply enable |
| backlight_en | output | 1 | Backlight enable |

## Verification
The sequencer's own update of the supply override and a software write to that same bit can land on the same clock edge. The bench provokes this by tracking the tick phase from reset. It sets a zero power-up delay and times a keyed write so that it coincides with the edge where the power-up phase completes. The override must then read back cleared, and a second identical write one phase later must set it, which shows that the earlier result came from the priority and not from the lock.

// File: rtl/ppsq_pkg.sv
package ppsq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_UP    = 3'd1,
    ST_ON    = 3'd2,
    ST_BLOFF = 3'd3,
    ST_DOWN  = 3'd4,
    ST_CYCLE = 3'd5
  } seq_state_t;

  localparam logic [15:0] UNLOCK_KEY = 16'hABCD;
  localparam int B_TARGET = 0;
  localparam int B_PRST   = 1;
  localparam int B_BLEN   = 2;
  localparam int B_FVDD   = 3;
  localparam logic [3:0] PROT_MASK = 4'b1011;
endpackage

// File: rtl/ppsq_tick.sv
module ppsq_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/ppsq_ctrl_reg.sv
module ppsq_ctrl_reg
  import ppsq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [15:0] wr_key,
  input  logic [3:0]  wr_bits,
  input  logic        hw_clr_fvdd,
  input  logic        hw_set_fvdd,
  input  logic        hw_clr_prst,
  output logic [3:0]  ctrl_q
);
  logic       key_ok;
  logic       upd_en;
  logic [3:0] merged;
  logic [3:0] ctrl_d;

  always_comb begin
    key_ok = (wr_key == UNLOCK_KEY);
    merged = key_ok ? wr_bits
                    : ((wr_bits & ~PROT_MASK) | (ctrl_q & PROT_MASK));
    ctrl_d = wr_ctrl ? merged : ctrl_q;
    // sequencer updates take priority over a same-cycle software write
    if (hw_clr_fvdd) ctrl_d[B_FVDD] = 1'b0;
    if (hw_set_fvdd) ctrl_d[B_FVDD] = 1'b1;
    if (hw_clr_prst) ctrl_d[B_PRST] = 1'b0;
    upd_en = wr_ctrl | hw_clr_fvdd | hw_set_fvdd | hw_clr_prst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (upd_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/ppsq_fsm.sv
module ppsq_fsm
  import ppsq_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int TO_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             target,
  input  logic             prst,
  input  logic [DLY_W-1:0] dly_up,
  input  logic [DLY_W-1:0] dly_bl_off,
  input  logic [DLY_W-1:0] dly_down,
  input  logic [DLY_W-1:0] dly_cycle,
  input  logic [TO_W-1:0]  max_ticks,
  input  logic             clr_tout,
  output seq_state_t       state_q,
  output logic             seq_vdd,
  output logic             on_flag,
  output logic             busy,
  output logic             enter_on,
  output logic             leave_rst,
  output logic             enter_off,
  output logic             tout_q
);
  seq_state_t       st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d, ld_val;
  logic             load, done, cnt_en;
  logic [TO_W-1:0]  tcnt_q, tcnt_d;
  logic             tout_set, tout_d;

  always_comb begin
    st_d   = state_q;
    load   = 1'b0;
    ld_val = '0;
    done   = tick && (cnt_q == '0);
    unique case (state_q)
      ST_OFF:   if (target) begin st_d = ST_UP; load = 1'b1; ld_val = dly_up; end
      ST_UP:    if (done) st_d = ST_ON;
      ST_ON:    if (!target || prst) begin st_d = ST_BLOFF; load = 1'b1; ld_val = dly_bl_off; end
      ST_BLOFF: if (done) begin st_d = ST_DOWN; load = 1'b1; ld_val = dly_down; end
      ST_DOWN:  if (done) begin st_d = ST_CYCLE; load = 1'b1; ld_val = dly_cycle; end
      ST_CYCLE: if (done) st_d = ST_OFF;
      default:  st_d = ST_OFF;
    endcase
    cnt_en = load | tick;
    cnt_d  = load ? ld_val : ((cnt_q != '0) ? cnt_q - 1'b1 : cnt_q);
  end

  always_comb begin
    enter_on  = (state_q == ST_UP) && (st_d == ST_ON);
    leave_rst = (state_q == ST_ON) && (st_d == ST_BLOFF) && prst;
    enter_off = (state_q == ST_CYCLE) && (st_d == ST_OFF);
    busy      = (state_q != ST_OFF) && (state_q != ST_ON);
    seq_vdd   = (state_q == ST_UP) || (state_q == ST_ON) || (state_q == ST_BLOFF);
    on_flag   = (state_q == ST_ON) || (state_q == ST_BLOFF) || (state_q == ST_DOWN);
    tcnt_d    = !busy ? '0
              : ((tick && tcnt_q != max_ticks) ? tcnt_q + 1'b1 : tcnt_q);
    tout_set  = busy && tick && (tcnt_q == max_ticks);
    tout_d    = tout_set ? 1'b1 : (clr_tout ? 1'b0 : tout_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      tcnt_q  <= '0;
      tout_q  <= 1'b0;
    end else begin
      state_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
      tcnt_q  <= tcnt_d;
      tout_q  <= tout_d;
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import ppsq_pkg::*;
#(
  parameter int TICK_DIV = 100,
  parameter int DLY_W    = 8,
  parameter int TO_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [DLY_W-1:0] dly_up,
  input  logic [DLY_W-1:0] dly_bl_off,
  input  logic [DLY_W-1:0] dly_down,
  input  logic [DLY_W-1:0] dly_cycle,
  input  logic [TO_W-1:0]  max_ticks,
  output logic [31:0]      ctrl_rd,
  output logic [31:0]      status,
  output logic             panel_vdd,
  output logic             backlight_en
);
  logic       tick;
  logic [3:0] ctrl_q;
  seq_state_t state_q;
  logic       seq_vdd, on_flag, busy, enter_on, leave_rst, enter_off, tout_q;
  logic       wr_ctrl, clr_tout;
  logic       unused_wr_bits;

  assign wr_ctrl        = wr_en && !wr_sel;
  assign clr_tout       = wr_en && wr_sel && wr_data[2];
  assign unused_wr_bits = ^wr_data[15:4];

  ppsq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  ppsq_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_key     (wr_data[31:16]),
    .wr_bits    (wr_data[3:0]),
    .hw_clr_fvdd(enter_on),
    .hw_set_fvdd(enter_off),
    .hw_clr_prst(leave_rst),
    .ctrl_q     (ctrl_q)
  );

  ppsq_fsm #(.DLY_W(DLY_W), .TO_W(TO_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .target    (ctrl_q[B_TARGET]),
    .prst      (ctrl_q[B_PRST]),
    .dly_up    (dly_up),
    .dly_bl_off(dly_bl_off),
    .dly_down  (dly_down),
    .dly_cycle (dly_cycle),
    .max_ticks (max_ticks),
    .clr_tout  (clr_tout),
    .state_q   (state_q),
    .seq_vdd   (seq_vdd),
    .on_flag   (on_flag),
    .busy      (busy),
    .enter_on  (enter_on),
    .leave_rst (leave_rst),
    .enter_off (enter_off),
    .tout_q    (tout_q)
  );

  assign ctrl_rd      = {28'd0, ctrl_q};
  assign status       = {25'd0, state_q, 1'b0, tout_q, busy, on_flag};
  assign panel_vdd    = seq_vdd | ctrl_q[B_FVDD];
  assign backlight_en = (state_q == ST_ON) && ctrl_q[B_BLEN];
endmodule

// File: rtl/ppsq_chk.sv
module ppsq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] ctrl_rd,
  input logic [31:0] status,
  input logic        panel_vdd,
  input logic        backlight_en
);
  logic unused_chk;
  assign unused_chk = ^{wr_data[15:3], wr_data[1:0], ctrl_rd[31:4], ctrl_rd[2:1],
                        status[31:7], status[3], status[1]};

  assert_bl_needs_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    backlight_en |-> (panel_vdd && status[6:4] == 3'd2));

  assert_on_has_vdd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6:4] == 3'd2) |-> (panel_vdd && status[0]));

  assert_fvdd_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6:4] == 3'd2 && $past(status[6:4]) == 3'd1) |-> !ctrl_rd[3]);

  assert_fvdd_reassert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6:4] == 3'd0 && $past(status[6:4]) == 3'd5) |-> ctrl_rd[3]);

  assert_tout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !(wr_en && wr_sel && wr_data[2])) |=> status[2]);

  assert_lock_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[31:16] != 16'hABCD && status[6:4] == 3'd0 && !ctrl_rd[0])
    |=> !ctrl_rd[0]);
endmodule

bind panel_pwr_seq ppsq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .ctrl_rd     (ctrl_rd),
  .status      (status),
  .panel_vdd   (panel_vdd),
  .backlight_en(backlight_en)
);

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  d_up = 8'd5, d_bl = 8'd2, d_down = 8'd3, d_cyc = 8'd2;
  logic [11:0] max_t = 12'd200;
  logic [31:0] ctrl_rd, status;
  logic        panel_vdd, backlight_en;

  int edges = 0;
  int n_tests = 0;
  int n_fail = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  panel_pwr_seq #(.TICK_DIV(DIV), .DLY_W(8), .TO_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dly_up(d_up), .dly_bl_off(d_bl), .dly_down(d_down), .dly_cycle(d_cyc),
    .max_ticks(max_t), .ctrl_rd(ctrl_rd), .status(status),
    .panel_vdd(panel_vdd), .backlight_en(backlight_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_state(input logic [2:0] code, input int lim);
    int n = 0;
    while (status[6:4] !== code && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 ctrl", ctrl_rd, 32'h0);
    check("R1 status", status, 32'h0);
    check("R1 vdd", {31'd0, panel_vdd}, 32'd0);
    check("R1 backlight", {31'd0, backlight_en}, 32'd0);
  endtask

  task automatic t_lock();
    wr(1'b0, 32'h0000_000F);
    check("R2 unkeyed write only bit2", ctrl_rd, 32'h4);
    check("R2 unkeyed target ignored state", {29'd0, status[6:4]}, 32'd0);
    check("R2 unkeyed override ignored vdd", {31'd0, panel_vdd}, 32'd0);
    wr(1'b0, 32'hABCD_0008);
    check("R2 keyed write", ctrl_rd, 32'h8);
    check("R11 override vdd", {31'd0, panel_vdd}, 32'd1);
    check("R11 on stays low", {31'd0, status[0]}, 32'd0);
    wr(1'b0, 32'h1234_0000);
    check("R2 wrong key keeps bit3", ctrl_rd, 32'h8);
  endtask

  task automatic t_power_up();
    int n = 0;
    logic bl_early = 1'b0;
    d_up = 8'd5;
    wr(1'b0, 32'hABCD_000D);
    while (!status[0] && n < 200) begin
      if (backlight_en) bl_early = 1'b1;
      @(posedge clk); @(negedge clk);
      n++;
    end
    check($sformatf("R3 on after %0d cycles in 22..25", n), {31'd0, (n >= 22 && n <= 25)}, 32'd1);
    check("R3 on state code", {29'd0, status[6:4]}, 32'd2);
    check("R3 vdd", {31'd0, panel_vdd}, 32'd1);
    check("R4 override released at on", {31'd0, ctrl_rd[3]}, 32'd0);
    check("R5 backlight low during power-up", {31'd0, bl_early}, 32'd0);
    check("R5 backlight on", {31'd0, backlight_en}, 32'd1);
  endtask

  task automatic t_power_down();
    int n = 0;
    int bl_at = -1, vdd_at = -1, on_at = -1;
    wr(1'b0, 32'hABCD_0004);
    while (n < 300) begin
      if (bl_at < 0 && !backlight_en) bl_at = n;
      if (vdd_at < 0 && !panel_vdd) vdd_at = n;
      if (on_at < 0 && !status[0]) on_at = n;
      if (n > 0 && status[6:4] == 3'd0) break;
      @(posedge clk); @(negedge clk);
      n++;
    end
    check("R6 reached off", {29'd0, status[6:4]}, 32'd0);
    check($sformatf("R6 order bl=%0d vdd=%0d on=%0d", bl_at, vdd_at, on_at),
          {31'd0, (bl_at >= 0 && bl_at < vdd_at && vdd_at < on_at)}, 32'd1);
    check("R5 backlight dropped first", {31'd0, (bl_at == 1)}, 32'd1);
    check("R4 override reasserted at off", {31'd0, ctrl_rd[3]}, 32'd1);
    check("R6 on cleared", {31'd0, status[0]}, 32'd0);
  endtask

  task automatic t_reversal();
    int n = 0;
    logic saw_on = 1'b0, glitch = 1'b0;
    wr(1'b0, 32'hABCD_0000);
    check("R7 pre vdd off", {31'd0, panel_vdd}, 32'd0);
    d_up = 8'd4;
    wr(1'b0, 32'hABCD_0001);
    while (n < 400) begin
      if (status[6:4] == 3'd2) saw_on = 1'b1;
      if (n >= 1 && !saw_on && !panel_vdd) glitch = 1'b1;
      if (saw_on && status[6:4] == 3'd0) break;
      if (n == 2) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'hABCD_0000; end
      else begin wr_en = 1'b0; wr_data = '0; end
      @(posedge clk); @(negedge clk);
      n++;
    end
    wr_en = 1'b0; wr_data = '0;
    check("R7 on reached after reversal", {31'd0, saw_on}, 32'd1);
    check("R7 no supply drop before on", {31'd0, glitch}, 32'd0);
    check("R7 back to off", {29'd0, status[6:4]}, 32'd0);
  endtask

  task automatic t_preset();
    int n = 0;
    logic saw_down = 1'b0, saw_low = 1'b0;
    d_up = 8'd2;
    wr(1'b0, 32'hABCD_0001);
    wait_state(3'd2, 200);
    wr(1'b0, 32'hABCD_0003);
    while (n < 400) begin
      if (status[6:4] == 3'd4) saw_down = 1'b1;
      if (!panel_vdd) saw_low = 1'b1;
      if (saw_down && status[6:4] == 3'd2) break;
      @(posedge clk); @(negedge clk);
      n++;
    end
    check("R8 passed through power-down", {31'd0, saw_down}, 32'd1);
    check("R8 supply cycled", {31'd0, saw_low}, 32'd1);
    check("R8 on again", {31'd0, status[0]}, 32'd1);
    check("R8 reset bit self-cleared, target kept", ctrl_rd[1:0], 32'h1);
    wr(1'b0, 32'hABCD_0000);
    wait_state(3'd0, 400);
  endtask

  task automatic t_timeout();
    d_up = 8'd10; max_t = 12'd3;
    wr(1'b0, 32'hABCD_0001);
    wait_state(3'd2, 300);
    check("R9 timeout set", {31'd0, status[2]}, 32'd1);
    wr(1'b1, 32'h0000_0004);
    check("R9 timeout cleared by write-one", {31'd0, status[2]}, 32'd0);
    max_t = 12'd100;
    wr(1'b0, 32'hABCD_0000);
    wait_state(3'd0, 400);
    check("R9 no timeout within limit", {31'd0, status[2]}, 32'd0);
  endtask

  task automatic t_collision();
    d_up = 8'd0; max_t = 12'd200;
    @(negedge clk);
    while (((edges + 3) % DIV) != 0) @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'hABCD_0009;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b1; wr_data = 32'hABCD_0009;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check("R10 on reached in collision cycle", {29'd0, status[6:4]}, 32'd2);
    check("R10 sequencer clear wins", {31'd0, ctrl_rd[3]}, 32'd0);
    wr(1'b0, 32'hABCD_0009);
    check("R10 later write sets override", {31'd0, ctrl_rd[3]}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock();
    t_power_up();
    t_power_down();
    t_reversal();
    t_preset();
    t_timeout();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule